// File: doc/BRIEF.md
# Fully Associative Tagged Translation Buffer

This block caches virtual-to-physical page translations in a small, fully associative array. The entry count is a parameter and may be at most 64. Each slot holds the following:
- a virtual page number, a partition number, a 13-bit context and a real-mode flag, which together form the tag;
- a page frame number and a two-bit size code (8 KiB, 64 KiB, 512 KiB or 4 MiB);
- a lock flag, a valid flag and a used flag.

Lookups enter on a valid/ready request channel and leave on a registered valid/ready response channel. A request is accepted only when `lk_ready` is high. `lk_ready` is high when the response register is empty or being drained in the same cycle, and no command is presented that cycle. A response stays stable while `rs_ready` is low. Lookups and commands both use the partition from the `part_id` input.

Maintenance goes through a register-style command port that is always accepted. The port does four things:
- writes the tag-access register;
- loads entries, either into a slot the block chooses or into an explicit slot;
- demaps by page, by context or by partition;
- flushes the whole array.

Replacement follows a used-bit scheme. When every used bit would be set, all of them are cleared except the newest one.

Top module: `tlb_fa`

## Requirements
- R1: After reset no response is pending, `lk_ready` is high and every entry is invalid, so any lookup misses.
- R2: A lookup hits only on a valid entry whose partition equals `part_id` and whose context and real flag equal the request's. The virtual page must also agree above the entry's page size, where size code s gives a page of 2^(13+3s) bytes. A hit returns `rs_pa` as the frame bits above the page offset joined with the request address bits below it, together with the slot in `rs_idx`. A miss returns `rs_hit`=0.
- R3: A load command (`cmd_op`=2, or 3 for indexed) takes its real flag from `cmd_addr[9]`. `cmd_addr[10]` picks the data format. With format 0, size is `cmd_data[62:61]` and lock is `cmd_data[6]`. With format 1, size is `cmd_data[1:0]` and lock is `cmd_data[61]`. In both formats the frame is `cmd_data[39:13]`.
- R4: Command `cmd_op`=1 writes `cmd_data` into the tag-access register. A load takes its virtual page from bits 63:13 of that register and its context from bits 12:0.
- R5: Before a load writes its slot, every valid entry is invalidated that has the same partition, context and real flag as the new entry and an overlapping virtual range at the larger of the two page sizes. At most one entry can then hit any lookup.
- R6: A non-indexed load writes the lowest-numbered free slot. If no slot is free, it writes the lowest unlocked slot whose used flag is clear. Failing that it writes the lowest unlocked slot, and failing that the last slot.
- R7: A hit sets that entry's used flag only when `lk_upd` is high. A probe with `lk_upd` low leaves the flag unchanged. A load sets the new entry's used flag.
- R8: When setting a used flag would leave every used flag set, all used flags are cleared except the one just set.
- R9: An indexed load writes the slot given by `cmd_addr[8:3]`. If that value is not below the entry count, the command has no effect.
- R10: A demap (`cmd_op`=4) has its kind in `cmd_addr[7:6]` and its context in `cmd_addr[5:4]`. Kind 0 removes one page: the page is `cmd_data[63:13]` and the real flag is `cmd_addr[9]`. Kind 1 removes every entry of a context within the partition. The context select is 0 for primary (`pri_ctx`), 1 for secondary (`sec_ctx`) and 3 for nucleus (context 0). Context select 2 and kind 3 do nothing.
- R11: A partition demap (kind 2) removes every valid unlocked entry of the current partition. Locked entries survive it.
- R12: A flush (`cmd_op`=5) clears the valid and used flags of every entry in one cycle, locked entries included.
- R13: `lk_ready` is low whenever `cmd_valid` is high, or when a response is held with `rs_ready` low. A held response keeps `rs_hit`, `rs_idx` and `rs_pa` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| part_id | input | 8 | Current partition, used for lookups, loads and demaps |
| pri_ctx | input | 13 | Primary context for demap select 0 |
| sec_ctx | input | 13 | Secondary context for demap select 1 |
| lk_valid | input | 1 | Lookup request valid |
| lk_ready | output | 1 | Lookup request accepted this cycle when high |
| lk_va | input | 64 | Lookup virtual address |
| lk_ctx | input | 13 | Lookup context |
| lk_rm | input | 1 | Lookup real-mode flag |
| lk_upd | input | 1 | Set the used flag on a hit |
| rs_valid | output | 1 | Response valid |
| rs_ready | input | 1 | Response consumer ready |
| rs_hit | output | 1 | Lookup hit |
| rs_idx | output | clog2(ENTRIES) | Slot that hit |
| rs_pa | output | 40 | Translated physical address |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 3 | 1 tag write, 2 load, 3 indexed load, 4 demap, 5 flush |
| cmd_addr | input | 11 | Command selector field |
| cmd_data | input | 64 | Command data word |

## Verification
The hardest state to reach is a full array in which the used flags have just rolled over, since only that state lets the fallback victim choice show. The bench loads exactly as many entries as there are slots, with some of them locked. It refreshes part of the array with used-updating lookups and touches another entry with a probe only. It then loads one more page and shows by later lookups which old mapping disappeared. A reference model kept as plain arrays predicts every response, and the bench compares it with the design each clock, including across a stalled response.

// File: rtl/tlb_fa_pkg.sv
package tlb_fa_pkg;
  localparam int VA_W   = 64;
  localparam int PG_LSB = 13;
  localparam int VPN_W  = VA_W - PG_LSB;
  localparam int CTX_W  = 13;
  localparam int PART_W = 8;
  localparam int PA_W   = 40;
  localparam int PPN_W  = PA_W - PG_LSB;
  localparam int SZ_W   = 2;

  typedef enum logic [2:0] {
    OP_NOP      = 3'd0,
    OP_TAG_WR   = 3'd1,
    OP_LOAD     = 3'd2,
    OP_LOAD_IDX = 3'd3,
    OP_DEMAP    = 3'd4,
    OP_FLUSH    = 3'd5
  } op_e;

  typedef struct packed {
    logic [VPN_W-1:0]  vpn;
    logic [PPN_W-1:0]  ppn;
    logic [CTX_W-1:0]  ctx;
    logic [PART_W-1:0] part;
    logic              rm;
    logic [SZ_W-1:0]   size;
    logic              lock;
  } ent_t;

  // virtual page bits that take part in a compare for a page size code
  function automatic logic [VPN_W-1:0] vpn_mask(logic [SZ_W-1:0] sz);
    return {VPN_W{1'b1}} << (3 * sz);
  endfunction

  // byte-offset bits of a page of the given size code
  function automatic logic [PA_W-1:0] off_mask(logic [SZ_W-1:0] sz);
    return (PA_W'(1) << (PG_LSB + 3 * sz)) - PA_W'(1);
  endfunction
endpackage

// File: rtl/tlb_fa_cmd_dec.sv
module tlb_fa_cmd_dec
  import tlb_fa_pkg::*;
#(
  parameter int ENTRIES = 16,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic              cmd_valid,
  input  logic [2:0]        cmd_op,
  input  logic [10:0]       cmd_addr,
  input  logic [63:0]       cmd_data,
  input  logic [CTX_W-1:0]  pri_ctx,
  input  logic [CTX_W-1:0]  sec_ctx,
  output logic              do_tag_wr,
  output logic              do_load,
  output logic              load_at_idx,
  output logic [IDX_W-1:0]  load_idx,
  output logic              load_rm,
  output logic [SZ_W-1:0]   load_size,
  output logic              load_lock,
  output logic [PPN_W-1:0]  load_ppn,
  output logic              do_demap,
  output logic              dm_use_va,
  output logic              dm_use_ctx,
  output logic              dm_use_rm,
  output logic              dm_skip_lock,
  output logic [CTX_W-1:0]  dm_ctx,
  output logic              dm_rm,
  output logic [VPN_W-1:0]  dm_vpn,
  output logic              do_flush
);
  op_e        op;
  logic [1:0] dm_kind;
  logic [1:0] dm_sel;
  logic       ctx_ok;
  logic       unused_bits;

  assign op          = op_e'(cmd_op);
  assign dm_kind     = cmd_addr[7:6];
  assign dm_sel      = cmd_addr[5:4];
  assign unused_bits = ^{cmd_addr[2:0], cmd_data[12:7], cmd_data[5:2]};

  always_comb begin
    do_tag_wr    = 1'b0;
    do_load      = 1'b0;
    load_at_idx  = 1'b0;
    load_idx     = IDX_W'(cmd_addr[8:3]);
    load_rm      = cmd_addr[9];
    load_ppn     = cmd_data[PA_W-1:PG_LSB];
    if (cmd_addr[10]) begin
      load_size = cmd_data[1:0];
      load_lock = cmd_data[61];
    end else begin
      load_size = cmd_data[62:61];
      load_lock = cmd_data[6];
    end
    do_demap     = 1'b0;
    dm_use_va    = 1'b0;
    dm_use_ctx   = 1'b0;
    dm_use_rm    = 1'b0;
    dm_skip_lock = 1'b0;
    dm_rm        = cmd_addr[9];
    dm_vpn       = cmd_data[VA_W-1:PG_LSB];
    do_flush     = 1'b0;
    ctx_ok       = 1'b1;
    case (dm_sel)
      2'd0:    dm_ctx = pri_ctx;
      2'd1:    dm_ctx = sec_ctx;
      2'd3:    dm_ctx = '0;
      default: begin dm_ctx = '0; ctx_ok = 1'b0; end
    endcase
    case (op)
      OP_TAG_WR:   do_tag_wr = cmd_valid;
      OP_LOAD:     do_load   = cmd_valid;
      OP_LOAD_IDX: begin
        load_at_idx = 1'b1;
        do_load     = cmd_valid && (int'(cmd_addr[8:3]) < ENTRIES);
      end
      OP_DEMAP: begin
        case (dm_kind)
          2'd0: begin
            dm_use_va  = 1'b1;
            dm_use_ctx = 1'b1;
            dm_use_rm  = 1'b1;
            do_demap   = cmd_valid && ctx_ok;
          end
          2'd1: begin
            dm_use_ctx = 1'b1;
            do_demap   = cmd_valid && ctx_ok;
          end
          2'd2: begin
            dm_skip_lock = 1'b1;
            do_demap     = cmd_valid;
          end
          default: do_demap = 1'b0;
        endcase
      end
      OP_FLUSH: do_flush = cmd_valid;
      default:  ;
    endcase
  end
endmodule

// File: rtl/tlb_fa_match.sv
module tlb_fa_match
  import tlb_fa_pkg::*;
#(
  parameter int ENTRIES = 16
) (
  input  ent_t [ENTRIES-1:0] ents,
  input  logic [ENTRIES-1:0] valid,
  input  logic [VPN_W-1:0]   q_vpn,
  input  logic [SZ_W-1:0]    q_size,
  input  logic [CTX_W-1:0]   q_ctx,
  input  logic [PART_W-1:0]  q_part,
  input  logic               q_rm,
  input  logic               use_va,
  input  logic               use_ctx,
  input  logic               use_rm,
  input  logic               skip_locked,
  output logic [ENTRIES-1:0] hits
);
  for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
    logic [SZ_W-1:0] cmp_sz;
    logic            va_ok, ctx_ok, rm_ok, lock_ok;
    assign cmp_sz  = (ents[i].size > q_size) ? ents[i].size : q_size;
    assign va_ok   = !use_va || (((ents[i].vpn ^ q_vpn) & vpn_mask(cmp_sz)) == '0);
    assign ctx_ok  = !use_ctx || (ents[i].ctx == q_ctx);
    assign rm_ok   = !use_rm || (ents[i].rm == q_rm);
    assign lock_ok = !skip_locked || !ents[i].lock;
    assign hits[i] = valid[i] && (ents[i].part == q_part) && va_ok && ctx_ok
                     && rm_ok && lock_ok;
  end
endmodule

// File: rtl/tlb_fa_pick.sv
module tlb_fa_pick #(
  parameter int ENTRIES = 16,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic [ENTRIES-1:0] free_v,
  input  logic [ENTRIES-1:0] cand_v,
  input  logic [ENTRIES-1:0] unlocked_v,
  output logic [IDX_W-1:0]   idx
);
  always_comb begin
    idx = IDX_W'(ENTRIES - 1);
    if (|free_v) begin
      for (int i = ENTRIES - 1; i >= 0; i--) if (free_v[i]) idx = IDX_W'(i);
    end else if (|cand_v) begin
      for (int i = ENTRIES - 1; i >= 0; i--) if (cand_v[i]) idx = IDX_W'(i);
    end else if (|unlocked_v) begin
      for (int i = ENTRIES - 1; i >= 0; i--) if (unlocked_v[i]) idx = IDX_W'(i);
    end
  end
endmodule

// File: rtl/tlb_fa.sv
module tlb_fa
  import tlb_fa_pkg::*;
#(
  parameter int ENTRIES = 16,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [7:0]        part_id,
  input  logic [12:0]       pri_ctx,
  input  logic [12:0]       sec_ctx,
  input  logic              lk_valid,
  output logic              lk_ready,
  input  logic [63:0]       lk_va,
  input  logic [12:0]       lk_ctx,
  input  logic              lk_rm,
  input  logic              lk_upd,
  output logic              rs_valid,
  input  logic              rs_ready,
  output logic              rs_hit,
  output logic [IDX_W-1:0]  rs_idx,
  output logic [39:0]       rs_pa,
  input  logic              cmd_valid,
  input  logic [2:0]        cmd_op,
  input  logic [10:0]       cmd_addr,
  input  logic [63:0]       cmd_data
);
  ent_t [ENTRIES-1:0] ents_q, ents_n;
  logic [ENTRIES-1:0] valid_q, valid_n, used_q, used_n, lock_v;
  logic [VA_W-1:0]    tag_q;

  // command decode
  logic             do_tag_wr, do_load, load_at_idx, load_rm, load_lock;
  logic [IDX_W-1:0] load_idx;
  logic [SZ_W-1:0]  load_size;
  logic [PPN_W-1:0] load_ppn;
  logic             do_demap, dm_use_va, dm_use_ctx, dm_use_rm, dm_skip_lock, dm_rm;
  logic [CTX_W-1:0] dm_ctx;
  logic [VPN_W-1:0] dm_vpn;
  logic             do_flush;

  tlb_fa_cmd_dec #(.ENTRIES(ENTRIES)) u_dec (
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_data(cmd_data),
    .pri_ctx(pri_ctx), .sec_ctx(sec_ctx),
    .do_tag_wr(do_tag_wr), .do_load(do_load), .load_at_idx(load_at_idx),
    .load_idx(load_idx), .load_rm(load_rm), .load_size(load_size),
    .load_lock(load_lock), .load_ppn(load_ppn),
    .do_demap(do_demap), .dm_use_va(dm_use_va), .dm_use_ctx(dm_use_ctx),
    .dm_use_rm(dm_use_rm), .dm_skip_lock(dm_skip_lock), .dm_ctx(dm_ctx),
    .dm_rm(dm_rm), .dm_vpn(dm_vpn), .do_flush(do_flush)
  );

  for (genvar i = 0; i < ENTRIES; i++) begin : g_lock
    assign lock_v[i] = ents_q[i].lock;
  end

  // lookup path
  logic [ENTRIES-1:0] lk_hits;
  logic               lk_any, lk_fire;
  logic [IDX_W-1:0]   lk_idx;
  logic [PA_W-1:0]    lk_pa;
  ent_t               lk_ent;

  tlb_fa_match #(.ENTRIES(ENTRIES)) u_lk_match (
    .ents(ents_q), .valid(valid_q), .q_vpn(lk_va[VA_W-1:PG_LSB]), .q_size('0),
    .q_ctx(lk_ctx), .q_part(part_id), .q_rm(lk_rm),
    .use_va(1'b1), .use_ctx(1'b1), .use_rm(1'b1), .skip_locked(1'b0),
    .hits(lk_hits)
  );

  always_comb begin
    lk_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) if (lk_hits[i]) lk_idx = IDX_W'(i);
  end

  assign lk_any   = |lk_hits;
  assign lk_ent   = ents_q[lk_idx];
  assign lk_pa    = ({lk_ent.ppn, {PG_LSB{1'b0}}} & ~off_mask(lk_ent.size))
                  | (lk_va[PA_W-1:0] & off_mask(lk_ent.size));
  assign lk_ready = (!rs_valid || rs_ready) && !cmd_valid;
  assign lk_fire  = lk_valid && lk_ready;

  // conflict search for a load, and demap search
  logic [ENTRIES-1:0] cf_hits, dm_hits;

  tlb_fa_match #(.ENTRIES(ENTRIES)) u_cf_match (
    .ents(ents_q), .valid(valid_q), .q_vpn(tag_q[VA_W-1:PG_LSB]), .q_size(load_size),
    .q_ctx(tag_q[CTX_W-1:0]), .q_part(part_id), .q_rm(load_rm),
    .use_va(1'b1), .use_ctx(1'b1), .use_rm(1'b1), .skip_locked(1'b0),
    .hits(cf_hits)
  );

  tlb_fa_match #(.ENTRIES(ENTRIES)) u_dm_match (
    .ents(ents_q), .valid(valid_q), .q_vpn(dm_vpn), .q_size('0),
    .q_ctx(dm_ctx), .q_part(part_id), .q_rm(dm_rm),
    .use_va(dm_use_va), .use_ctx(dm_use_ctx), .use_rm(dm_use_rm),
    .skip_locked(dm_skip_lock), .hits(dm_hits)
  );

  // victim choice after conflicting entries are dropped
  logic [ENTRIES-1:0] valid_ac, used_ac;
  logic [IDX_W-1:0]   pick_idx, tgt;

  assign valid_ac = valid_q & ~cf_hits;
  assign used_ac  = used_q & ~cf_hits;

  tlb_fa_pick #(.ENTRIES(ENTRIES)) u_pick (
    .free_v(~valid_ac), .cand_v(valid_ac & ~lock_v & ~used_ac),
    .unlocked_v(~lock_v), .idx(pick_idx)
  );

  assign tgt = load_at_idx ? load_idx : pick_idx;

  ent_t new_ent;
  always_comb begin
    new_ent.vpn  = tag_q[VA_W-1:PG_LSB];
    new_ent.ppn  = load_ppn;
    new_ent.ctx  = tag_q[CTX_W-1:0];
    new_ent.part = part_id;
    new_ent.rm   = load_rm;
    new_ent.size = load_size;
    new_ent.lock = load_lock;
  end

  always_comb begin
    ents_n  = ents_q;
    valid_n = valid_q;
    used_n  = used_q;
    if (do_flush) begin
      valid_n = '0;
      used_n  = '0;
    end else if (do_demap) begin
      valid_n = valid_q & ~dm_hits;
      used_n  = used_q & ~dm_hits;
    end else if (do_load) begin
      valid_n      = valid_ac;
      used_n       = used_ac;
      valid_n[tgt] = 1'b1;
      used_n[tgt]  = 1'b1;
      ents_n[tgt]  = new_ent;
      if (&used_n) begin
        used_n      = '0;
        used_n[tgt] = 1'b1;
      end
    end else if (lk_fire && lk_any && lk_upd) begin
      used_n[lk_idx] = 1'b1;
      if (&used_n) begin
        used_n         = '0;
        used_n[lk_idx] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ents_q  <= '0;
      valid_q <= '0;
      used_q  <= '0;
      tag_q   <= '0;
    end else begin
      ents_q  <= ents_n;
      valid_q <= valid_n;
      used_q  <= used_n;
      if (do_tag_wr) tag_q <= cmd_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_valid <= 1'b0;
      rs_hit   <= 1'b0;
      rs_idx   <= '0;
      rs_pa    <= '0;
    end else if (lk_fire) begin
      rs_valid <= 1'b1;
      rs_hit   <= lk_any;
      rs_idx   <= lk_any ? lk_idx : '0;
      rs_pa    <= lk_any ? lk_pa : '0;
    end else if (rs_ready) begin
      rs_valid <= 1'b0;
    end
  end

  // assertions
  a_r13_hold_resp: assert property (@(posedge clk) disable iff (!rst_n)
    rs_valid && !rs_ready |=> rs_valid && $stable(rs_hit) && $stable(rs_idx) && $stable(rs_pa));

  a_r13_accept_resp: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid && lk_ready |=> rs_valid);

  a_r5_single_hit: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lk_hits));

  a_r8_used_below_full: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(used_q) < ENTRIES);

  a_r7_used_only_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (used_q & ~valid_q) == '0);

  a_r12_flush_clears: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_op == 3'd5 |=> valid_q == '0 && used_q == '0);

  a_r11_locked_survive: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_op == 3'd4 && cmd_addr[7:6] == 2'd2
    |=> ($past(valid_q & lock_v) & ~valid_q) == '0);
endmodule

// File: tb/tlb_fa_bench.sv
module tlb_fa_bench;
  localparam int N  = 8;
  localparam int IW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [7:0]    part_id = 8'h05;
  logic [12:0]   pri_ctx = 13'h011, sec_ctx = 13'h022;
  logic          lk_valid = 0, lk_rm = 0, lk_upd = 0, rs_ready = 1;
  logic [63:0]   lk_va = 0;
  logic [12:0]   lk_ctx = 0;
  logic          lk_ready, rs_valid, rs_hit;
  logic [IW-1:0] rs_idx;
  logic [39:0]   rs_pa;
  logic          cmd_valid = 0;
  logic [2:0]    cmd_op = 0;
  logic [10:0]   cmd_addr = 0;
  logic [63:0]   cmd_data = 0;

  tlb_fa #(.ENTRIES(N)) u_tlb_fa (
    .clk(clk), .rst_n(rst_n), .part_id(part_id), .pri_ctx(pri_ctx), .sec_ctx(sec_ctx),
    .lk_valid(lk_valid), .lk_ready(lk_ready), .lk_va(lk_va), .lk_ctx(lk_ctx),
    .lk_rm(lk_rm), .lk_upd(lk_upd), .rs_valid(rs_valid), .rs_ready(rs_ready),
    .rs_hit(rs_hit), .rs_idx(rs_idx), .rs_pa(rs_pa), .cmd_valid(cmd_valid),
    .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_data(cmd_data)
  );

  int checks = 0, fails = 0;
  bit done = 0;

  // reference model
  logic        m_v[N], m_u[N], m_rm[N], m_lk[N];
  logic [50:0] m_vpn[N];
  logic [26:0] m_ppn[N];
  logic [12:0] m_ctx[N];
  logic [7:0]  m_part[N];
  logic [1:0]  m_sz[N];
  logic [63:0] m_tag;
  logic        m_rsv = 0;

  task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic bit same_page(logic [50:0] a, logic [50:0] b, int lvl);
    return (a >> (3 * lvl)) == (b >> (3 * lvl));
  endfunction

  function automatic void roll(int k);
    int c = 0;
    for (int i = 0; i < N; i++) if (m_u[i]) c++;
    if (c == N) begin
      for (int i = 0; i < N; i++) m_u[i] = 0;
      m_u[k] = 1;
    end
  endfunction

  function automatic void model_reset();
    for (int i = 0; i < N; i++) begin
      m_v[i] = 0; m_u[i] = 0; m_rm[i] = 0; m_lk[i] = 0;
      m_vpn[i] = 0; m_ppn[i] = 0; m_ctx[i] = 0; m_part[i] = 0; m_sz[i] = 0;
    end
    m_tag = 0;
  endfunction

  function automatic void model_cmd(logic [2:0] op, logic [10:0] a, logic [63:0] d);
    if (op == 3'd1) m_tag = d;
    else if (op == 3'd2 || op == 3'd3) begin
      logic [1:0] sz; logic lk; logic rm; int t;
      if (op == 3'd3 && int'(a[8:3]) >= N) return;
      rm = a[9];
      if (a[10]) begin sz = d[1:0]; lk = d[61]; end
      else begin sz = d[62:61]; lk = d[6]; end
      for (int i = 0; i < N; i++)
        if (m_v[i] && m_part[i] == part_id && m_ctx[i] == m_tag[12:0] && m_rm[i] == rm &&
            same_page(m_vpn[i], m_tag[63:13], (m_sz[i] > sz) ? int'(m_sz[i]) : int'(sz))) begin
          m_v[i] = 0; m_u[i] = 0;
        end
      t = -1;
      if (op == 3'd3) t = int'(a[8:3]);
      for (int i = 0; i < N && t < 0; i++) if (!m_v[i]) t = i;
      for (int i = 0; i < N && t < 0; i++) if (!m_lk[i] && !m_u[i]) t = i;
      for (int i = 0; i < N && t < 0; i++) if (!m_lk[i]) t = i;
      if (t < 0) t = N - 1;
      m_v[t] = 1; m_u[t] = 1; m_vpn[t] = m_tag[63:13]; m_ctx[t] = m_tag[12:0];
      m_ppn[t] = d[39:13]; m_part[t] = part_id; m_rm[t] = rm; m_sz[t] = sz; m_lk[t] = lk;
      roll(t);
    end else if (op == 3'd4) begin
      logic [12:0] c; bit ok; logic [1:0] ty;
      ty = a[7:6]; ok = 1;
      case (a[5:4])
        2'd0: c = pri_ctx;
        2'd1: c = sec_ctx;
        2'd3: c = 0;
        default: begin c = 0; ok = 0; end
      endcase
      for (int i = 0; i < N; i++) begin
        bit kill = 0;
        if (m_v[i] && m_part[i] == part_id) begin
          if (ty == 0 && ok) kill = (m_ctx[i] == c) && (m_rm[i] == a[9]) &&
                                    same_page(m_vpn[i], d[63:13], int'(m_sz[i]));
          if (ty == 1 && ok) kill = (m_ctx[i] == c);
          if (ty == 2)       kill = !m_lk[i];
        end
        if (kill) begin m_v[i] = 0; m_u[i] = 0; end
      end
    end else if (op == 3'd5) begin
      for (int i = 0; i < N; i++) begin m_v[i] = 0; m_u[i] = 0; end
    end
  endfunction

  // per-clock comparison of the handshake against the model
  always @(posedge clk)
    if (!rst_n) m_rsv <= 0;
    else if (lk_valid && (!m_rsv || rs_ready) && !cmd_valid) m_rsv <= 1;
    else if (rs_ready) m_rsv <= 0;

  always @(negedge clk)
    if (rst_n && !done) begin
      chk("R13", "rs_valid", 64'(rs_valid), 64'(m_rsv));
      chk("R13", "lk_ready", 64'(lk_ready), 64'((!m_rsv || rs_ready) && !cmd_valid));
    end

  task automatic cmd(logic [2:0] op, logic [10:0] a, logic [63:0] d);
    @(negedge clk);
    cmd_valid = 1; cmd_op = op; cmd_addr = a; cmd_data = d;
    model_cmd(op, a, d);
    @(posedge clk); #1;
    cmd_valid = 0; cmd_op = 0;
  endtask

  task automatic look(string req, logic [63:0] va, logic [12:0] ctx, logic rm, logic upd,
                      int stall);
    bit hit = 0; int hi = 0; logic [63:0] pa = 0;
    for (int i = N - 1; i >= 0; i--)
      if (m_v[i] && m_part[i] == part_id && m_ctx[i] == ctx && m_rm[i] == rm &&
          same_page(m_vpn[i], va[63:13], int'(m_sz[i]))) begin
        hit = 1; hi = i;
      end
    if (hit) begin
      int sh = 13 + 3 * int'(m_sz[hi]);
      logic [63:0] om = (64'd1 << sh) - 1;
      pa = (({37'd0, m_ppn[hi]} << 13) & ~om) | (va & om);
      pa = pa & 64'hFF_FFFF_FFFF;
    end
    if (stall > 0) begin
      @(posedge clk); #1; rs_ready = 0;
    end
    @(negedge clk);
    lk_valid = 1; lk_va = va; lk_ctx = ctx; lk_rm = rm; lk_upd = upd;
    if (hit && upd) begin m_u[hi] = 1; roll(hi); end
    @(posedge clk); #1;
    lk_valid = 0;
    for (int s = 0; s <= stall; s++) begin
      @(negedge clk);
      chk(req, "rs_valid", 64'(rs_valid), 64'd1);
      chk(req, "rs_hit", 64'(rs_hit), 64'(hit));
      if (hit) begin
        chk(req, "rs_pa", 64'(rs_pa), pa);
        chk(req, "rs_idx", 64'(rs_idx), 64'(hi));
      end
    end
    if (stall > 0) begin
      @(posedge clk); #1; rs_ready = 1;
    end
  endtask

  function automatic logic [63:0] fmt0(logic [26:0] ppn, logic [1:0] sz, logic lk);
    return (64'(sz) << 61) | (64'(ppn) << 13) | (64'(lk) << 6);
  endfunction
  function automatic logic [63:0] fmt1(logic [26:0] ppn, logic [1:0] sz, logic lk);
    return (64'(lk) << 61) | (64'(ppn) << 13) | 64'(sz);
  endfunction
  function automatic logic [63:0] tagv(logic [63:0] va, logic [12:0] c);
    return {va[63:13], c};
  endfunction
  function automatic logic [10:0] ld_a(logic f, logic rm, logic [5:0] idx);
    return {f, rm, idx, 3'b000};
  endfunction
  function automatic logic [10:0] dm_a(logic rm, logic [1:0] ty, logic [1:0] cs);
    return {1'b0, rm, 1'b0, ty, cs, 4'b0000};
  endfunction

  task automatic load(logic [63:0] va, logic [12:0] c, logic [10:0] a, logic [63:0] d);
    cmd(3'd1, 11'd0, tagv(va, c));
    cmd((a[8:3] != 0) ? 3'd3 : 3'd2, a, d);
  endtask

  task automatic finish_up();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #(4 * 150000);
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_up();
  end

  initial begin
    model_reset();
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk("R1", "rs_valid after reset", 64'(rs_valid), 64'd0);
    chk("R1", "lk_ready after reset", 64'(lk_ready), 64'd1);
    look("R1", 64'h2000, 13'h011, 0, 1, 0);

    // R2 R3 R4: format 0, 8 KiB page
    load(64'h0000_1234_5678_0000, 13'h011, ld_a(0, 0, 0), fmt0(27'h100, 2'd0, 0));
    look("R2", 64'h0000_1234_5678_0123, 13'h011, 0, 1, 0);
    // format 1, 512 KiB page, real flag set
    load(64'h0000_0000_4000_0000, 13'h011, ld_a(1, 1, 0), fmt1(27'h4000, 2'd2, 0));
    look("R3", 64'h0000_0000_4005_4321, 13'h011, 1, 1, 0);
    look("R3", 64'h0000_0000_4005_4321, 13'h011, 0, 1, 0);
    look("R2", 64'h0000_1234_5678_0123, 13'h012, 0, 1, 0);
    part_id = 8'h06;
    look("R2", 64'h0000_1234_5678_0123, 13'h011, 0, 1, 0);
    part_id = 8'h05;
    // R5: remap the same page; 64 KiB mapping overlapping the 8 KiB one
    load(64'h0000_1234_5678_0000, 13'h011, ld_a(0, 0, 0), fmt0(27'h208, 2'd1, 0));
    look("R5", 64'h0000_1234_5678_0456, 13'h011, 0, 1, 0);
    look("R5", 64'h0000_1234_567F_0010, 13'h011, 0, 1, 0);
    // R10: page demap
    cmd(3'd4, dm_a(0, 2'd0, 2'd0), 64'h0000_1234_5678_2000);
    look("R10", 64'h0000_1234_5678_0456, 13'h011, 0, 1, 0);
    look("R10", 64'h0000_0000_4005_4321, 13'h011, 1, 1, 0);
    // R10: context demaps, secondary and nucleus, select 2 ignored
    load(64'h0000_0000_0010_0000, 13'h022, ld_a(0, 0, 0), fmt0(27'h300, 2'd0, 0));
    load(64'h0000_0000_0020_0000, 13'h000, ld_a(0, 0, 0), fmt0(27'h301, 2'd0, 0));
    cmd(3'd4, dm_a(0, 2'd1, 2'd2), 64'd0);
    look("R10", 64'h0000_0000_0010_0004, 13'h022, 0, 1, 0);
    cmd(3'd4, dm_a(0, 2'd1, 2'd1), 64'd0);
    look("R10", 64'h0000_0000_0010_0004, 13'h022, 0, 1, 0);
    look("R10", 64'h0000_0000_0020_0008, 13'h000, 0, 1, 0);
    cmd(3'd4, dm_a(0, 2'd1, 2'd3), 64'd0);
    look("R10", 64'h0000_0000_0020_0008, 13'h000, 0, 1, 0);
    // R12: flush
    cmd(3'd5, 11'd0, 64'd0);
    look("R12", 64'h0000_0000_4005_4321, 13'h011, 1, 1, 0);

    // R6 R7 R8: fill, rollover, victim choice
    for (int i = 0; i < N; i++)
      load(64'h1_0000_0000 + 64'(i) * 64'h2000, 13'h011, ld_a(0, 0, 0),
           fmt0(27'h500 + 27'(i), 2'd0, (i == 1 || i == 2)));
    for (int i = 0; i < 4; i++)
      look("R7", 64'h1_0000_0000 + 64'(i) * 64'h2000 + 64'h10, 13'h011, 0, 1, 0);
    look("R7", 64'h1_0000_8000, 13'h011, 0, 0, 0);
    load(64'h2_0000_0000, 13'h011, ld_a(0, 0, 0), fmt0(27'h600, 2'd0, 0));
    for (int i = 0; i < N; i++)
      look("R6", 64'h1_0000_0000 + 64'(i) * 64'h2000, 13'h011, 0, 0, 0);
    look("R8", 64'h2_0000_0020, 13'h011, 0, 1, 0);
    load(64'h3_0000_0000, 13'h011, ld_a(0, 0, 0), fmt0(27'h601, 2'd0, 0));
    load(64'h3_0000_2000, 13'h011, ld_a(0, 0, 0), fmt0(27'h602, 2'd0, 0));
    look("R8", 64'h3_0000_2000, 13'h011, 0, 0, 0);
    for (int i = 0; i < N; i++)
      look("R6", 64'h1_0000_0000 + 64'(i) * 64'h2000, 13'h011, 0, 0, 0);

    // R11: partition demap spares locked entries
    cmd(3'd4, dm_a(0, 2'd2, 2'd0), 64'd0);
    for (int i = 0; i < 4; i++)
      look("R11", 64'h1_0000_0000 + 64'(i) * 64'h2000, 13'h011, 0, 0, 0);
    look("R11", 64'h2_0000_0000, 13'h011, 0, 0, 0);

    // R9: indexed load, in range and out of range
    load(64'h4_0000_0000, 13'h011, ld_a(0, 0, 6), fmt0(27'h700, 2'd0, 0));
    look("R9", 64'h4_0000_0100, 13'h011, 0, 1, 0);
    load(64'h5_0000_0000, 13'h011, ld_a(0, 0, 9), fmt0(27'h701, 2'd0, 0));
    look("R9", 64'h5_0000_0100, 13'h011, 0, 1, 0);

    // R13: held response under back-pressure
    look("R13", 64'h4_0000_0200, 13'h011, 0, 1, 3);

    // R12: flush removes locked entries too
    cmd(3'd5, 11'd0, 64'd0);
    look("R12", 64'h1_0000_2000, 13'h011, 0, 0, 0);
    look("R12", 64'h1_0000_4000, 13'h011, 0, 0, 0);

    repeat (2) @(negedge clk);
    finish_up();
  end
endmodule